// File: doc/BRIEF.md
# External Edge-Port Interrupt Module

This block watches seven external pins, numbered 1 to 7, and turns activity on them into one interrupt request line per pin for a downstream interrupt controller. Position 0 exists in every register and output vector but is reserved: it never stores a value and never requests. Each pin is brought into the clock domain through a synchronizer. A two-bit trigger field then makes the pin either level-sensitive (active low, no acknowledge needed) or sensitive to rising edges, falling edges or both. Edge events are held in sticky flags that software acknowledges by writing ones.

Software configures the block through a small register window with byte and halfword accesses. Besides the trigger fields there is a direction byte, an enable byte, an output-data byte that drives pins set as outputs, a read-only view of the synchronized pin levels, and the flag byte. Every register clears on reset, so all pins start as level-sensitive inputs with requests disabled.

Byte map (address: content): 0 trigger bits 15:8, 1 trigger bits 7:0, 2 direction, 3 enable, 4 output data, 5 synchronized pin levels (read-only), 6 flags (write-one-to-clear), 7 reserved (reads zero). The trigger field of pin p sits at bits 2p+1:2p, with code 00 level, 01 rising, 10 falling, 11 both.

Top module: `extirq_port`

## Requirements
- R1: After reset every register reads zero (byte 5 reads the synchronized pins, which are held high during reset), irq is zero, and pinOutEn and pinOut are zero.
- R2: A byte access (busHalf=0) uses byte busAddr on busWrData[7:0] / busRdData[7:0], with busRdData[15:8] zero; a halfword access (busHalf=1) ignores busAddr[0] and maps the even byte to bits 15:8 and the odd byte to bits 7:0.
- R3: Position 0 is reserved: bit 0 of the direction, enable, output-data, pin-level and flag bytes and trigger bits 1:0 always read 0, and irq[0] is never asserted.
- R4: In level mode (code 00) the flag bit reads 1 exactly while the synchronized pin is low, irq follows it when enabled, a change on pinIn appears on irq two clock edges later, and writing 1 to its flag has no effect.
- R5: With code 01 a low-to-high change on the pin sets the flag on the third clock edge after the change; a high-to-low change does not.
- R6: With code 10 only high-to-low changes set the flag; with code 11 both directions set it.
- R7: An edge-mode flag stays set until a 1 is written to its bit of byte 6; writing 0 leaves it unchanged and other bits are unaffected.
- R8: When a write-one-to-clear and a new qualifying edge land in the same cycle, the flag remains set.
- R9: Edge flags set whether or not the pin is enabled; enabling a pin with a pending flag raises its irq on the next cycle.
- R10: pinOutEn equals the direction byte and pinOut equals output data ANDed with direction; pinOutEn changes only after a register write.
- R11: Byte 5 returns the synchronized pin levels; writes to it are ignored.
- R12: irq of a pin with its enable bit clear is always 0; irq of an enabled pin equals its flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe, one cycle per write |
| busHalf | input | 1 | 1 selects a halfword access, 0 a byte access |
| busAddr | input | 3 | Byte address of the access |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for the current address and size (combinational) |
| pinIn | input | 8 | Asynchronous external pin levels, bit 0 reserved |
| pinOut | output | 8 | Output data for pins configured as outputs |
| pinOutEn | output | 8 | Output enable per pin (1 = output) |
| irq | output | 8 | Interrupt request per pin toward the controller |

## Verification
The properties assume that busWr is low throughout reset and that pinIn holds its levels long enough for the synchronizer delay to be measured against a fixed past depth. The sticky-flag property also assumes that only a written one clears a flag, which holds because no other clearing source exists outside a switch to level mode. The stimulus keeps busWr low during reset, changes pins only on falling clock edges, and after each pin change waits at least four cycles before the next register write or pin change. The one exception is the directed collision case, which deliberately places a clear on the edge that sets a flag.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
package extirq_pkg;
  // Number of bit positions per register (position 0 reserved)
  localparam int PIN_POS   = 8;
  localparam int TRIG_W    = 2 * PIN_POS;
  localparam int REG_BYTES = 8;
  localparam int ADDR_W    = $clog2(REG_BYTES);

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_e;

  localparam logic [ADDR_W-1:0] ADR_TRIG_HI = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_TRIG_LO = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_DIR     = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_IEN     = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DOUT    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_LEVEL   = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_FLAG    = 3'd6;

  // Strobes from the bus control to the datapath
  typedef struct packed {
    logic [REG_BYTES-1:0]        we;
    logic [REG_BYTES-1:0][7:0]   wdata;
  } strobe_t;
endpackage

// File: rtl/extirq_ctrl.sv
`timescale 1ns/1ps
module extirq_ctrl
  import extirq_pkg::*;
(
  input  logic                      busWr,
  input  logic                      busHalf,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [15:0]               busWrData,
  output logic [15:0]               busRdData,
  input  logic [REG_BYTES-1:0][7:0] regBytes,
  output strobe_t                   strobe
);
  logic [ADDR_W-1:0] evenAddr;
  logic [ADDR_W-1:0] oddAddr;

  assign evenAddr = {busAddr[ADDR_W-1:1], 1'b0};
  assign oddAddr  = {busAddr[ADDR_W-1:1], 1'b1};

  // Byte-lane write decode: even byte on the upper lane for halfwords
  always_comb begin
    strobe = '0;
    if (busWr) begin
      if (busHalf) begin
        strobe.we[evenAddr]    = 1'b1;
        strobe.wdata[evenAddr] = busWrData[15:8];
        strobe.we[oddAddr]     = 1'b1;
        strobe.wdata[oddAddr]  = busWrData[7:0];
      end else begin
        strobe.we[busAddr]     = 1'b1;
        strobe.wdata[busAddr]  = busWrData[7:0];
      end
    end
  end

  // Read mux with the same lane arrangement
  assign busRdData = busHalf ? {regBytes[evenAddr], regBytes[oddAddr]}
                             : {8'h00, regBytes[busAddr]};
endmodule

// File: rtl/extirq_datapath.sv
`timescale 1ns/1ps
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PIN_POS-1:0]        pinIn,
  input  strobe_t                   strobe,
  output logic [REG_BYTES-1:0][7:0] regBytes,
  output logic [PIN_POS-1:0]        irq,
  output logic [PIN_POS-1:0]        pinOut,
  output logic [PIN_POS-1:0]        pinOutEn
);
  localparam logic [PIN_POS-1:0] LIVE_MASK = {{(PIN_POS-1){1'b1}}, 1'b0};
  localparam logic [TRIG_W-1:0]  TRIG_MASK = {{(TRIG_W-2){1'b1}}, 2'b00};

  logic [TRIG_W-1:0]                   trigQ;
  logic [PIN_POS-1:0]                  dirQ, ienQ, doutQ, flagQ;
  logic [SYNC_STAGES-1:0][PIN_POS-1:0] syncQ;
  logic [PIN_POS-1:0]                  pinSync, pinPrev;
  logic [PIN_POS-1:0]                  edgeHit, levelMode, clrMask, flagNext, flagView;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ <= '0;
      dirQ  <= '0;
      ienQ  <= '0;
      doutQ <= '0;
    end else begin
      if (strobe.we[ADR_TRIG_HI]) trigQ[15:8] <= strobe.wdata[ADR_TRIG_HI] & TRIG_MASK[15:8];
      if (strobe.we[ADR_TRIG_LO]) trigQ[7:0]  <= strobe.wdata[ADR_TRIG_LO] & TRIG_MASK[7:0];
      if (strobe.we[ADR_DIR])     dirQ  <= strobe.wdata[ADR_DIR]  & LIVE_MASK;
      if (strobe.we[ADR_IEN])     ienQ  <= strobe.wdata[ADR_IEN]  & LIVE_MASK;
      if (strobe.we[ADR_DOUT])    doutQ <= strobe.wdata[ADR_DOUT] & LIVE_MASK;
    end
  end

  // Pin synchronizer and previous-value register; idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      pinPrev <= '1;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      pinPrev <= pinSync;
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];

  // Per-pin trigger decode
  for (genvar p = 0; p < PIN_POS; p++) begin : g_pin
    trig_e mode;
    logic  riseEv, fallEv;
    assign mode         = trig_e'(trigQ[2*p +: 2]);
    assign riseEv       = pinSync[p] & ~pinPrev[p];
    assign fallEv       = ~pinSync[p] & pinPrev[p];
    assign levelMode[p] = (mode == TRIG_LEVEL);
    assign edgeHit[p]   = (mode == TRIG_RISE) ? riseEv :
                          (mode == TRIG_FALL) ? fallEv :
                          (mode == TRIG_BOTH) ? (riseEv | fallEv) : 1'b0;
  end

  // Sticky edge flags: a new edge wins over a simultaneous clear
  assign clrMask  = strobe.we[ADR_FLAG] ? strobe.wdata[ADR_FLAG] : '0;
  assign flagNext = LIVE_MASK & ~levelMode & ((flagQ & ~clrMask) | edgeHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNext;
  end

  // Level pins report their live active-low state instead of a stored flag
  assign flagView = LIVE_MASK & ((levelMode & ~pinSync) | (~levelMode & flagQ));

  assign irq      = flagView & ienQ;
  assign pinOutEn = dirQ;
  assign pinOut   = doutQ & dirQ;

  assign regBytes[ADR_TRIG_HI] = trigQ[15:8];
  assign regBytes[ADR_TRIG_LO] = trigQ[7:0];
  assign regBytes[ADR_DIR]     = dirQ;
  assign regBytes[ADR_IEN]     = ienQ;
  assign regBytes[ADR_DOUT]    = doutQ;
  assign regBytes[ADR_LEVEL]   = pinSync & LIVE_MASK;
  assign regBytes[ADR_FLAG]    = flagView;
  assign regBytes[7]           = 8'h00;

  // Strobes for read-only and reserved bytes are deliberately dropped
  logic unusedBits;
  assign unusedBits = ^{strobe.we[ADR_LEVEL], strobe.wdata[ADR_LEVEL],
                        strobe.we[7], strobe.wdata[7]};
endmodule

// File: rtl/extirq_port.sv
`timescale 1ns/1ps
module extirq_port
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busHalf,
  input  logic [2:0]        busAddr,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  input  logic [7:0]        pinIn,
  output logic [7:0]        pinOut,
  output logic [7:0]        pinOutEn,
  output logic [7:0]        irq
);
  strobe_t                   strobe;
  logic [REG_BYTES-1:0][7:0] regBytes;

  extirq_ctrl i_ctrl (
    .busWr     (busWr),
    .busHalf   (busHalf),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .regBytes  (regBytes),
    .strobe    (strobe)
  );

  extirq_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .strobe   (strobe),
    .regBytes (regBytes),
    .irq      (irq),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn)
  );
endmodule

// File: rtl/extirq_checker.sv
`timescale 1ns/1ps
module extirq_checker
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input logic               clk,
  input logic               rstN,
  input logic               busWr,
  input logic [PIN_POS-1:0] pinIn,
  input logic [PIN_POS-1:0] irq,
  input logic [PIN_POS-1:0] pinOutEn,
  input logic [TRIG_W-1:0]  trigWord,
  input logic [PIN_POS-1:0] ienByte,
  input logic [PIN_POS-1:0] flagByte,
  input logic               clrWe,
  input logic [PIN_POS-1:0] clrData
);
  // R3: reserved position never requests nor flags
  a_r3_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (irq[0] == 1'b0) && (flagByte[0] == 1'b0));

  // R12: a request needs its enable bit
  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~ienByte) == '0);

  // R10: output enables only move after a register write
  a_r10_dir_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> $stable(pinOutEn));

  for (genvar p = 1; p < PIN_POS; p++) begin : g_bit
    logic isLevel;
    assign isLevel = (trigWord[2*p +: 2] == 2'b00);

    // R4: a level request implies the pin was low one synchronizer delay ago
    a_r4_level_tracks_pin: assert property (@(posedge clk) disable iff (!rstN)
      (isLevel && irq[p]) |-> ($past(pinIn[p], SYNC_STAGES) == 1'b0));

    // R7: an edge flag survives any cycle without a clear of its bit
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (!isLevel && flagByte[p] && !(clrWe && clrData[p])) |=> (flagByte[p] || isLevel));
  end
endmodule

bind extirq_port extirq_checker #(.SYNC_STAGES(SYNC_STAGES)) i_extirq_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .pinIn    (pinIn),
  .irq      (irq),
  .pinOutEn (pinOutEn),
  .trigWord ({regBytes[0], regBytes[1]}),
  .ienByte  (regBytes[3]),
  .flagByte (regBytes[6]),
  .clrWe    (strobe.we[6]),
  .clrData  (strobe.wdata[6])
);

// File: tb/test_extirq_port.sv
`timescale 1ns/1ps
module test_extirq_port;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busHalf = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [7:0]  pinIn = 8'hFF;
  logic [7:0]  pinOut, pinOutEn, irq;

  int nChecks = 0;
  int nFail   = 0;

  // Bench model of the programmed state
  logic [15:0] mTrig = '0;
  logic [7:0]  mIen = '0, mFlag = '0, mPin = 8'hFF;

  always #2.5 clk = ~clk;

  extirq_port i_extirq_port (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busHalf(busHalf), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // All bus tasks start just after a falling edge
  task automatic wrByte(input logic [2:0] a, input logic [7:0] d);
    busWr = 1'b1; busHalf = 1'b0; busAddr = a; busWrData = {8'h00, d};
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic wrHalf(input logic [2:0] a, input logic [15:0] d);
    busWr = 1'b1; busHalf = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdByte(input logic [2:0] a, output logic [7:0] d);
    busHalf = 1'b0; busAddr = a; #1;
    d = busRdData[7:0];
  endtask

  task automatic rdHalf(input logic [2:0] a, output logic [15:0] d);
    busHalf = 1'b1; busAddr = a; #1;
    d = busRdData;
  endtask

  function automatic logic [7:0] levelMask(input logic [15:0] t);
    logic [7:0] m = '0;
    for (int p = 1; p < 8; p++) m[p] = (t[2*p +: 2] == 2'b00);
    return m;
  endfunction

  function automatic logic [7:0] expView();
    logic [7:0] v = '0;
    logic [7:0] lm = levelMask(mTrig);
    for (int p = 1; p < 8; p++) v[p] = lm[p] ? ~mPin[p] : mFlag[p];
    return v;
  endfunction

  function automatic logic [7:0] edgesFor(input logic [15:0] t, input logic [7:0] oldP,
                                          input logic [7:0] newP);
    logic [7:0] h = '0;
    for (int p = 1; p < 8; p++) begin
      logic r = newP[p] & ~oldP[p];
      logic f = ~newP[p] & oldP[p];
      case (t[2*p +: 2])
        2'b01:   h[p] = r;
        2'b10:   h[p] = f;
        2'b11:   h[p] = r | f;
        default: h[p] = 1'b0;
      endcase
    end
    return h;
  endfunction

  task automatic modelPins(input logic [7:0] v);
    pinIn = v;
    waitCycles(4);
    mFlag = mFlag | edgesFor(mTrig, mPin, v);
    mPin  = v;
  endtask

  task automatic modelTrig(input logic [15:0] t);
    wrHalf(3'd0, t);
    mTrig = t & 16'hFFFC;
    mFlag = mFlag & ~levelMask(mTrig);
    waitCycles(1);
  endtask

  task automatic checkState(input string req);
    logic [7:0] f;
    rdByte(3'd6, f);
    chk(req, {8'h00, f}, {8'h00, expView()});
    chk(req, {8'h00, irq}, {8'h00, expView() & mIen});
  endtask

  initial begin : main
    logic [15:0] h;
    logic [7:0]  b;
    void'($urandom(32'd20240611));

    waitCycles(3);
    // R1: reset state
    rdHalf(3'd0, h); chk("R1", h, 16'h0000);
    rdHalf(3'd2, h); chk("R1", h, 16'h0000);
    rdHalf(3'd4, h); chk("R1", h, 16'h00FE);
    rdHalf(3'd6, h); chk("R1", h, 16'h0000);
    chk("R1", {irq, pinOutEn}, 16'h0000);
    chk("R1", {8'h00, pinOut}, 16'h0000);
    @(negedge clk); rstN = 1'b1;
    waitCycles(2);

    // R2, R3: lane mapping and reserved bits
    wrHalf(3'd1, 16'hFFFF);                 // halfword ignores address bit 0
    rdHalf(3'd0, h); chk("R2", h, 16'hFFFC);
    wrByte(3'd1, 8'h00);
    rdHalf(3'd1, h); chk("R2", h, 16'hFF00);
    rdByte(3'd0, b); chk("R2", busRdData, 16'h00FF);
    wrHalf(3'd0, 16'h0000);
    wrByte(3'd2, 8'hFF);
    rdByte(3'd2, b); chk("R3", {8'h00, b}, 16'h00FE);
    // R10: output drive
    wrByte(3'd4, 8'hA5);
    chk("R10", {pinOutEn, pinOut}, 16'hFEA4);
    wrByte(3'd2, 8'h0F);
    chk("R10", {pinOutEn, pinOut}, 16'h0E04);
    wrByte(3'd2, 8'h00);
    chk("R10", {pinOutEn, pinOut}, 16'h0000);

    // R4: level mode on pin 3, latency two edges
    wrByte(3'd3, 8'hFF); mIen = 8'hFE;
    pinIn = 8'hF7;
    waitCycles(1); chk("R4", {8'h00, irq}, 16'h0000);
    waitCycles(1); chk("R4", {8'h00, irq}, 16'h0008);
    wrByte(3'd6, 8'h08);
    rdByte(3'd6, b); chk("R4", {8'h00, b}, 16'h0008);
    // R11: pin level view, write ignored
    wrByte(3'd5, 8'hFF);
    rdByte(3'd5, b); chk("R11", {8'h00, b}, 16'h00F6);
    pinIn = 8'hFF; waitCycles(2);
    chk("R4", {8'h00, irq}, 16'h0000);
    mPin = 8'hFF;

    // R5: rising edge on pin 1
    modelTrig(16'h0004);
    modelPins(8'hFD);
    chk("R5", {8'h00, irq}, 16'h0000);
    pinIn = 8'hFF;
    waitCycles(2); chk("R5", {8'h00, irq}, 16'h0000);
    waitCycles(1); chk("R5", {8'h00, irq}, 16'h0002);
    waitCycles(5); chk("R7", {8'h00, irq}, 16'h0002);
    mPin = 8'hFF; mFlag = 8'h02;
    wrByte(3'd6, 8'h00); checkState("R7");
    wrByte(3'd6, 8'h02); mFlag = 8'h00; checkState("R7");

    // R6: falling on pin 2, both on pin 7
    modelTrig(16'hC020);
    modelPins(8'h7B); checkState("R6");
    chk("R6", {8'h00, irq}, 16'h0084);
    wrByte(3'd6, 8'hFF); mFlag = 8'h00; checkState("R7");
    modelPins(8'hFF); checkState("R6");
    chk("R6", {8'h00, irq}, 16'h0080);
    wrByte(3'd6, 8'h80); mFlag = 8'h00; checkState("R7");

    // R8: clear lands on the same edge as a new event
    modelTrig(16'h000C);
    pinIn = 8'hFD;
    waitCycles(2);
    wrByte(3'd6, 8'h02);
    rdByte(3'd6, b); chk("R8", {8'h00, b}, 16'h0002);
    mPin = 8'hFD; mFlag = 8'h02;
    wrByte(3'd6, 8'h02); mFlag = 8'h00; checkState("R8");

    // R9, R12: flag while disabled, then enable
    wrByte(3'd3, 8'h00); mIen = 8'h00;
    modelPins(8'hFF);
    rdByte(3'd6, b); chk("R9", {8'h00, b}, 16'h0002);
    chk("R12", {8'h00, irq}, 16'h0000);
    wrByte(3'd3, 8'h02); mIen = 8'h02;
    chk("R9", {8'h00, irq}, 16'h0002);
    wrByte(3'd6, 8'h02); mFlag = 8'h00;

    // R3: reserved pin 0 activity is invisible
    wrByte(3'd3, 8'hFF); mIen = 8'hFE;
    modelTrig(16'hFFFF);
    modelPins(8'hFE);
    chk("R3", {8'h00, irq & 8'h01}, 16'h0000);
    modelPins(8'hFF);
    rdByte(3'd6, b); chk("R3", {8'h00, b & 8'h01}, 16'h0000);

    // Random phase
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: modelTrig(16'($urandom));
        1: begin b = 8'($urandom); wrByte(3'd3, b); mIen = b & 8'hFE; end
        2: begin b = 8'($urandom); wrByte(3'd6, b); mFlag = mFlag & ~b; end
        default: modelPins(8'($urandom));
      endcase
      checkState(op == 3 ? "R6" : (op == 2 ? "R7" : "R12"));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule